// File: doc/BRIEF.md
# Sync Polarity and Timing Analyzer

This block sits in the pixel clock domain and observes a raw horizontal sync and a raw vertical sync. It works out which level of each signal is the active pulse and re-emits both syncs as active-high. It also tells apart the two fields of an interlaced source. For each sync it measures the active pulse width and the full period. Horizontal values are counted in pixel clocks and vertical values in lines.

A host uses the results to identify the incoming video mode. It learns of a mode change or a lost signal through a single interrupt pulse. Each phase counter saturates. While a counter sits at its ceiling, the matching timeout flag stays high, and the rising edge of that flag raises the interrupt.

Top module: `sync_analyzer`

## Requirements
- R1: Each sync's polarity output is 1 (active high) until both of its phases have been measured once. From then on it is 1 when the last measured high phase is no longer than the last measured low phase, and 0 otherwise.
- R2: Each sync input is registered once. The normalized output equals that registered sample when the polarity output is 1, and its inverse when it is 0.
- R3: On the leading (active-going) edge of the normalized vertical sync, the block counts the pixel clocks since the last horizontal leading edge. This count is 0 when both edges fall in the same cycle. If the count is below half the reported horizontal period, field_odd becomes 1; otherwise it becomes 0. The flag holds between vertical leading edges.
- R4: h_width is the length in pixel clocks of the last measured active phase of horizontal sync. h_period is updated at each horizontal leading edge, once both phases are known, to the active length plus the length of the inactive phase that just ended.
- R5: v_width and v_period follow the R4 rules for vertical sync, with each horizontal leading edge counting as one unit.
- R6: Phase counters saturate at all ones, and so do the reported periods. A timeout flag is high while its counter is saturated.
- R7: irq pulses for one cycle, two cycles after a leading edge registers a new period whose absolute difference from the previous valid period exceeds the tolerance input for that sync.
- R8: irq pulses for one cycle on the cycle after either timeout flag rises.
- R9: After reset, both polarity outputs are 1, and all widths, periods, field_odd, the timeout flags and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_in | input | 1 | Raw horizontal sync |
| vs_in | input | 1 | Raw vertical sync |
| h_tol | input | HCW | Horizontal period change tolerance, in clocks |
| v_tol | input | VCW | Vertical period change tolerance, in lines |
| hs_norm | output | 1 | Horizontal sync, active high |
| vs_norm | output | 1 | Vertical sync, active high |
| hs_pol | output | 1 | Inferred horizontal polarity (1 = active high) |
| vs_pol | output | 1 | Inferred vertical polarity (1 = active high) |
| field_odd | output | 1 | 1 for an odd field, 0 for an even field |
| h_width | output | HCW | Horizontal active width in clocks |
| h_period | output | HCW | Horizontal period in clocks |
| v_width | output | VCW | Vertical active width in lines |
| v_period | output | VCW | Vertical period in lines |
| h_timeout | output | 1 | Horizontal phase counter saturated |
| v_timeout | output | 1 | Vertical phase counter saturated |
| irq | output | 1 | One-cycle change or loss interrupt |

## Verification
A wrong phase count or a wrong stored length shows up at the next sync edge. It appears as a wrong width or period, and polarity can also flip. The normalized output then inverts within one cycle of that edge. A wrong line position in the field tracker shows up only at the next vertical leading edge, as a wrong field_odd. A wrong stored period produces an interrupt that is missing or spurious two cycles after the following leading edge. The bench compares every output with its model on every cycle, so each of these faults is caught on the cycle where it first reaches a port.

// File: rtl/sync_pkg.sv
package sync_pkg;
    typedef enum logic {
        POL_LOW  = 1'b0,
        POL_HIGH = 1'b1
    } pol_e;

    typedef enum logic {
        FLD_EVEN = 1'b0,
        FLD_ODD  = 1'b1
    } field_e;

    localparam int HCW_DEF = 12;
    localparam int VCW_DEF = 11;
endpackage

// File: rtl/sync_meter.sv
module sync_meter
    import sync_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sig_in,
    input  logic         tick,
    input  logic [W-1:0] tol,
    output logic         norm,
    output logic         pol,
    output logic         lead,
    output logic         edge_o,
    output logic         evt,
    output logic         timeout,
    output logic [W-1:0] width,
    output logic [W-1:0] period
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic         sig_q, sig_d;
    logic [W-1:0] cnt, hi_len, lo_len, per_q;
    logic         hi_ok, lo_ok, per_ok, evt_q;
    logic         rise, fall;
    pol_e         pol_s;
    logic [W-1:0] act_len, per_new, diff, tick_w;
    logic [W:0]   sum;

    always_comb begin
        rise    = sig_q & ~sig_d;
        fall    = ~sig_q & sig_d;
        pol_s   = (hi_ok && lo_ok) ? ((hi_len <= lo_len) ? POL_HIGH : POL_LOW) : POL_HIGH;
        act_len = (pol_s == POL_HIGH) ? hi_len : lo_len;
        sum     = {1'b0, act_len} + {1'b0, cnt};
        per_new = sum[W] ? CMAX : sum[W-1:0];
        diff    = (per_new >= per_q) ? (per_new - per_q) : (per_q - per_new);
        tick_w  = tick ? ONE : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q  <= 1'b0;
            sig_d  <= 1'b0;
            cnt    <= '0;
            hi_len <= '0;
            lo_len <= '0;
            per_q  <= '0;
            hi_ok  <= 1'b0;
            lo_ok  <= 1'b0;
            per_ok <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            sig_q <= sig_in;
            sig_d <= sig_q;
            if (rise) begin
                lo_len <= cnt;
                lo_ok  <= 1'b1;
            end
            if (fall) begin
                hi_len <= cnt;
                hi_ok  <= 1'b1;
            end
            if (rise || fall)
                cnt <= tick_w;
            else if (cnt != CMAX)
                cnt <= cnt + tick_w;
            if (lead && hi_ok && lo_ok) begin
                per_q  <= per_new;
                per_ok <= 1'b1;
                evt_q  <= per_ok && (diff > tol);
            end else begin
                evt_q  <= 1'b0;
            end
        end
    end

    assign pol     = (pol_s == POL_HIGH);
    assign lead    = pol ? rise : fall;
    assign edge_o  = rise | fall;
    assign norm    = pol ? sig_q : ~sig_q;
    assign width   = act_len;
    assign period  = per_q;
    assign evt     = evt_q;
    assign timeout = (cnt == CMAX);
endmodule

// File: rtl/field_tracker.sv
module field_tracker
    import sync_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         h_lead,
    input  logic         v_lead,
    input  logic [W-1:0] h_period,
    output logic         field_odd
);
    localparam logic [W-1:0] PMAX = {W{1'b1}};

    logic [W-1:0] pos, since_h, half;
    field_e       fld;

    always_comb begin
        if (h_lead)
            since_h = '0;
        else if (pos == PMAX)
            since_h = PMAX;
        else
            since_h = pos + 1'b1;
        half = h_period >> 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
            fld <= FLD_EVEN;
        end else begin
            if (h_lead)
                pos <= '0;
            else if (pos != PMAX)
                pos <= pos + 1'b1;
            if (v_lead)
                fld <= (since_h < half) ? FLD_ODD : FLD_EVEN;
        end
    end

    assign field_odd = (fld == FLD_ODD);
endmodule

// File: rtl/sync_analyzer.sv
module sync_analyzer
    import sync_pkg::*;
#(
    parameter int HCW = HCW_DEF,
    parameter int VCW = VCW_DEF
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hs_in,
    input  logic           vs_in,
    input  logic [HCW-1:0] h_tol,
    input  logic [VCW-1:0] v_tol,
    output logic           hs_norm,
    output logic           vs_norm,
    output logic           hs_pol,
    output logic           vs_pol,
    output logic           field_odd,
    output logic [HCW-1:0] h_width,
    output logic [HCW-1:0] h_period,
    output logic [VCW-1:0] v_width,
    output logic [VCW-1:0] v_period,
    output logic           h_timeout,
    output logic           v_timeout,
    output logic           irq
);
    logic h_lead, v_lead, h_edge, v_edge, h_evt, v_evt;
    logic h_to_q, v_to_q, irq_q;

    sync_meter #(.W(HCW)) u_h (
        .clk(clk), .rst(rst), .sig_in(hs_in), .tick(1'b1), .tol(h_tol),
        .norm(hs_norm), .pol(hs_pol), .lead(h_lead), .edge_o(h_edge),
        .evt(h_evt), .timeout(h_timeout), .width(h_width), .period(h_period)
    );

    sync_meter #(.W(VCW)) u_v (
        .clk(clk), .rst(rst), .sig_in(vs_in), .tick(h_lead), .tol(v_tol),
        .norm(vs_norm), .pol(vs_pol), .lead(v_lead), .edge_o(v_edge),
        .evt(v_evt), .timeout(v_timeout), .width(v_width), .period(v_period)
    );

    field_tracker #(.W(HCW)) u_f (
        .clk(clk), .rst(rst), .h_lead(h_lead), .v_lead(v_lead),
        .h_period(h_period), .field_odd(field_odd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            h_to_q <= 1'b0;
            v_to_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            h_to_q <= h_timeout;
            v_to_q <= v_timeout;
            irq_q  <= h_evt | v_evt | (h_timeout & ~h_to_q) | (v_timeout & ~v_to_q);
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/sync_analyzer_chk.sv
module sync_analyzer_chk #(
    parameter int HCW = 12,
    parameter int VCW = 11
) (
    input logic           clk,
    input logic           rst,
    input logic           irq,
    input logic           h_evt,
    input logic           v_evt,
    input logic           h_to,
    input logic           v_to,
    input logic           h_lead,
    input logic           v_lead,
    input logic           h_edge,
    input logic           hs_pol,
    input logic           field_odd,
    input logic [HCW-1:0] h_period,
    input logic [VCW-1:0] v_period
);
    p_pol_on_edge_r1: assert property (@(posedge clk) disable iff (rst)
        !$stable(hs_pol) |-> $past(h_edge));
    p_field_on_vlead_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(field_odd) |-> $past(v_lead));
    p_hper_on_lead_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(h_period) |-> $past(h_lead));
    p_vper_on_lead_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(v_period) |-> $past(v_lead));
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(h_evt | v_evt | h_to | v_to));
endmodule

bind sync_analyzer sync_analyzer_chk #(.HCW(HCW), .VCW(VCW)) u_chk (
    .clk(clk), .rst(rst), .irq(irq), .h_evt(h_evt), .v_evt(v_evt),
    .h_to(h_timeout), .v_to(v_timeout), .h_lead(h_lead), .v_lead(v_lead),
    .h_edge(h_edge), .hs_pol(hs_pol), .field_odd(field_odd),
    .h_period(h_period), .v_period(v_period)
);

// File: tb/sim_sync_analyzer.sv
`timescale 1ns/1ps
module sim_sync_analyzer;
    localparam int HCW = 8;
    localparam int VCW = 6;
    localparam int HMAX = 255;
    localparam int VMAX = 63;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hs_in = 1'b0, vs_in = 1'b0;
    logic [HCW-1:0] h_tol = 8'd2;
    logic [VCW-1:0] v_tol = 6'd1;
    logic hs_norm, vs_norm, hs_pol, vs_pol, field_odd, h_timeout, v_timeout, irq;
    logic [HCW-1:0] h_width, h_period;
    logic [VCW-1:0] v_width, v_period;

    sync_analyzer #(.HCW(HCW), .VCW(VCW)) u0 (
        .clk(clk), .rst(rst), .hs_in(hs_in), .vs_in(vs_in), .h_tol(h_tol), .v_tol(v_tol),
        .hs_norm(hs_norm), .vs_norm(vs_norm), .hs_pol(hs_pol), .vs_pol(vs_pol),
        .field_odd(field_odd), .h_width(h_width), .h_period(h_period),
        .v_width(v_width), .v_period(v_period), .h_timeout(h_timeout),
        .v_timeout(v_timeout), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // generator settings
    int hper = 40, hw = 4, hneg = 0, vper = 20, vw = 3, vneg = 1, ilace = 0, hs_on = 1;
    int hpos = 0, line = 0, fr = 0;
    int irq_cnt = 0, fld_chg = 0, last_fld = 0;

    // reference model state, index 0 = horizontal, 1 = vertical
    int q[2], d[2], cnt[2], hi[2], lo[2], hv[2], lv[2], per[2], pv[2], evt[2], tod[2];
    int pos, fodd, irq_m;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int mpol(input int k);
        return (hv[k] && lv[k]) ? (hi[k] <= lo[k]) : 1;
    endfunction

    function automatic int mmin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic msync(input int k, input int sig, input int tick, input int mx,
                         input int tol, output int ld);
        int rise, fall, p, act, pn, df;
        rise = q[k] && !d[k];
        fall = !q[k] && d[k];
        p    = mpol(k);
        act  = p ? hi[k] : lo[k];
        ld   = p ? rise : fall;
        if (ld && hv[k] && lv[k]) begin
            pn = mmin(act + cnt[k], mx);
            df = (pn > per[k]) ? pn - per[k] : per[k] - pn;
            evt[k] = pv[k] && (df > tol);
            per[k] = pn;
            pv[k]  = 1;
        end else begin
            evt[k] = 0;
        end
        if (rise) begin lo[k] = cnt[k]; lv[k] = 1; end
        if (fall) begin hi[k] = cnt[k]; hv[k] = 1; end
        cnt[k] = (rise || fall) ? tick : mmin(cnt[k] + tick, mx);
        d[k] = q[k];
        q[k] = sig;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 2; k++) begin
                q[k] = 0; d[k] = 0; cnt[k] = 0; hi[k] = 0; lo[k] = 0; hv[k] = 0;
                lv[k] = 0; per[k] = 0; pv[k] = 0; evt[k] = 0; tod[k] = 0;
            end
            pos = 0; fodd = 0; irq_m = 0;
        end else begin
            int to0, to1, nirq, hp_old, hl, vl, since;
            to0 = (cnt[0] == HMAX);
            to1 = (cnt[1] == VMAX);
            nirq = evt[0] | evt[1] | (to0 & !tod[0]) | (to1 & !tod[1]);
            tod[0] = to0; tod[1] = to1;
            hp_old = per[0];
            msync(0, int'(hs_in), 1, HMAX, int'(h_tol), hl);
            msync(1, int'(vs_in), hl, VMAX, int'(v_tol), vl);
            since = hl ? 0 : mmin(pos + 1, HMAX);
            if (vl) fodd = (since < hp_old / 2);
            pos = hl ? 0 : mmin(pos + 1, HMAX);
            irq_m = nirq;
        end
    end

    // compare on every cycle, then drive the next input values
    always @(negedge clk) begin
        if (!rst && !done) begin
            int p0, p1;
            p0 = mpol(0); p1 = mpol(1);
            chk("R1 hs_pol", hs_pol, p0);
            chk("R1 vs_pol", vs_pol, p1);
            chk("R2 hs_norm", hs_norm, p0 ? q[0] : !q[0]);
            chk("R2 vs_norm", vs_norm, p1 ? q[1] : !q[1]);
            chk("R3 field_odd", field_odd, fodd);
            chk("R4 h_width", h_width, p0 ? hi[0] : lo[0]);
            chk("R4 h_period", h_period, per[0]);
            chk("R5 v_width", v_width, p1 ? hi[1] : lo[1]);
            chk("R5 v_period", v_period, per[1]);
            chk("R6 h_timeout", h_timeout, cnt[0] == HMAX);
            chk("R6 v_timeout", v_timeout, cnt[1] == VMAX);
            chk("R7 R8 irq", irq, irq_m);
            if (irq) irq_cnt++;
            if (int'(field_odd) != last_fld) begin fld_chg++; last_fld = field_odd; end
        end
        begin
            int t, vstart, vact;
            t = line * hper + hpos;
            vstart = (ilace != 0 && fr[0]) ? hper / 2 : 0;
            vact = (t >= vstart) && (t < vstart + vw * hper);
            hs_in <= (hs_on != 0) ? ((hpos < hw) ^ hneg[0]) : hneg[0];
            vs_in <= vact[0] ^ vneg[0];
            hpos++;
            if (hpos >= hper) begin
                hpos = 0; line++;
                if (line >= vper) begin line = 0; fr++; end
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk("R9 hs_pol", hs_pol, 1);
        chk("R9 vs_pol", vs_pol, 1);
        chk("R9 h_period", h_period, 0);
        chk("R9 v_width", v_width, 0);
        chk("R9 irq", irq, 0);
        chk("R9 field_odd", field_odd, 0);
        rst = 1'b0;

        // active-high horizontal, active-low vertical
        run(4 * 800);
        chk("R1 hs active high", hs_pol, 1);
        chk("R1 vs active low", vs_pol, 0);
        chk("R4 h_width 4", h_width, 4);
        chk("R4 h_period 40", h_period, 40);
        chk("R5 v_width 3", v_width, 3);
        chk("R5 v_period 20", v_period, 20);

        // swap both polarities
        hneg = 1; vneg = 0;
        run(3 * 800);
        chk("R1 hs active low", hs_pol, 0);
        chk("R1 vs active high", vs_pol, 1);
        chk("R4 h_width after swap", h_width, 4);

        // interlaced: alternate field offsets
        fld_chg = 0;
        ilace = 1;
        run(4 * 800);
        chk("R3 field toggles", int'(fld_chg >= 2), 1);

        // period change beyond tolerance
        ilace = 0;
        run(800);
        irq_cnt = 0;
        hper = 48;
        run(2 * 960);
        chk("R7 irq on change", int'(irq_cnt > 0), 1);
        irq_cnt = 0;
        hper = 49;
        run(2 * 980);
        chk("R7 no irq within tolerance", irq_cnt, 0);

        // loss of horizontal sync
        irq_cnt = 0;
        hs_on = 0;
        run(300);
        chk("R6 h_timeout set", h_timeout, 1);
        chk("R8 irq on loss", int'(irq_cnt > 0), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule